// File: doc/BRIEF.md
# Fractional-N Feedback Divider with Pulse Swallowing

This block divides a stream of oscillator-rate enable pulses by a ratio whose long-run average is N plus F/4096. A 12-bit phase accumulator adds the fractional word F once per reference tick. When that addition carries out of the top bit, a removal is armed. The next oscillator enable is then swallowed before it reaches the integer divide-by-N counter. That division period therefore takes one more input pulse than N.

The counter emits one feedback pulse per completed period. The accumulator contents are exposed as a residue word, which tracks the instantaneous phase error and can drive an external compensation converter. New N and F words are sampled only when a period completes, so a ratio change never splits a period.

Top module: `frac_n_divider`

## Requirements
- R1: While reset is held and just after it, fb_pulse and remove_cmd are 0 and acc_residue is 0.
- R2: With no removal armed, fb_pulse goes high for one clock, in the cycle after the edge that accepts the N-th vco_en of the period.
- R3: Each ref_tick adds the active F to acc_residue modulo 4096. Without a ref_tick, acc_residue holds its value.
- R4: A ref_tick whose addition carries past bit 11 sets remove_cmd in the following cycle.
- R5: remove_cmd stays high until the next vco_en. That enable is swallowed and not counted, and remove_cmd returns low after it unless a new carry arrives on the same edge.
- R6: A division period that contains a swallowed enable spans N+1 vco_en pulses.
- R7: With one ref_tick per period, F=2048 makes the period lengths alternate N, N+1, starting with N. F=1024 lengthens every fourth period. A larger F therefore gives more long periods.
- R8: Changes on n_in and f_in take effect only at the edge that completes a period. Ticks and counts before that edge use the old values.
- R9: With F=0, ref_ticks never raise remove_cmd, and every period spans exactly N enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vco_en | input | 1 | One cycle per oscillator input pulse |
| ref_tick | input | 1 | One cycle per reference period |
| n_in | input | NW (8) | Integer divide value, at least 2 |
| f_in | input | ACC_W (12) | Fractional word added per reference tick |
| fb_pulse | output | 1 | Divided feedback pulse, one clock wide |
| remove_cmd | output | 1 | High while a removal is armed |
| acc_residue | output | ACC_W (12) | Phase accumulator contents |

## Verification
The hardest state to reach from the ports is an armed removal that meets a specific point of a period. Its effect is visible only as a period one enable longer than N. The bench first flushes a known N and F across a period boundary with ref_tick held low, which leaves the counter empty and the accumulator at zero. It then issues ref_ticks and enables one at a time, so the exact tick that carries and the exact enable that is swallowed are known in advance. A third sequence changes the inputs in mid-period to expose when the new values are taken.

// File: rtl/frac_n_pkg.sv
package frac_n_pkg;
   // How the feedback pulse leaves the integer counter.
   typedef enum logic {
      FB_REGISTERED = 1'b0,
      FB_DIRECT     = 1'b1
   } fb_mode_e;
endpackage

// File: rtl/frac_n_accum.sv
module frac_n_accum #(
   parameter int ACC_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [ACC_W-1:0] f_add,
   output logic [ACC_W-1:0] residue,
   output logic             carry
);
   logic [ACC_W:0]   sum;
   logic [ACC_W-1:0] acc_q;

   assign sum     = {1'b0, acc_q} + {1'b0, f_add};
   assign carry   = tick & sum[ACC_W];
   assign residue = acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc_q <= '0;
      else if (tick) acc_q <= sum[ACC_W-1:0];
   end
endmodule

// File: rtl/frac_n_swallow.sv
module frac_n_swallow (
   input  logic clk,
   input  logic rst_n,
   input  logic carry,
   input  logic vco_en,
   output logic remove_cmd,
   output logic pass_en
);
   logic armed_q;

   // An armed removal eats the next enable.
   assign pass_en    = vco_en & ~armed_q;
   assign remove_cmd = armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      armed_q <= 1'b0;
      else if (carry)  armed_q <= 1'b1;
      else if (vco_en) armed_q <= 1'b0;
   end
endmodule

// File: rtl/frac_n_count.sv
module frac_n_count
   import frac_n_pkg::*;
#(
   parameter int       NW      = 8,
   parameter int       N_RST   = 4,
   parameter fb_mode_e FB_MODE = FB_REGISTERED
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pass_en,
   input  logic [NW-1:0] n_in,
   output logic          boundary,
   output logic          fb_pulse
);
   localparam logic [NW-1:0] N_INIT = NW'(N_RST);
   localparam logic [NW-1:0] ONE    = NW'(1);

   logic [NW-1:0] cnt_q;
   logic [NW-1:0] n_act_q;

   assign boundary = pass_en && (cnt_q == n_act_q - ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         n_act_q <= N_INIT;
      end else if (boundary) begin
         cnt_q   <= '0;
         n_act_q <= n_in;
      end else if (pass_en) begin
         cnt_q   <= cnt_q + ONE;
      end
   end

   generate
      if (FB_MODE == FB_REGISTERED) begin : g_fb_reg
         logic fb_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fb_q <= 1'b0;
            else        fb_q <= boundary;
         end
         assign fb_pulse = fb_q;
      end else begin : g_fb_direct
         assign fb_pulse = boundary;
      end
   endgenerate
endmodule

// File: rtl/frac_n_divider.sv
module frac_n_divider
   import frac_n_pkg::*;
#(
   parameter int       ACC_W   = 12,
   parameter int       NW      = 8,
   parameter int       N_RST   = 4,
   parameter fb_mode_e FB_MODE = FB_REGISTERED
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vco_en,
   input  logic             ref_tick,
   input  logic [NW-1:0]    n_in,
   input  logic [ACC_W-1:0] f_in,
   output logic             fb_pulse,
   output logic             remove_cmd,
   output logic [ACC_W-1:0] acc_residue
);
   generate
      if (ACC_W < 2) begin : g_bad_acc
         $error("ACC_W must be at least 2");
      end
      if (NW < 2) begin : g_bad_nw
         $error("NW must be at least 2");
      end
      if (N_RST < 2 || N_RST >= (1 << NW)) begin : g_bad_nrst
         $error("N_RST must lie in 2 .. 2**NW-1");
      end
   endgenerate

   logic             carry;
   logic             pass_en;
   logic             boundary;
   logic [ACC_W-1:0] f_act_q;

   // The fractional word follows the integer word: both change at a boundary.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        f_act_q <= '0;
      else if (boundary) f_act_q <= f_in;
   end

   frac_n_accum #(.ACC_W(ACC_W)) u_accum (
      .clk(clk), .rst_n(rst_n), .tick(ref_tick), .f_add(f_act_q),
      .residue(acc_residue), .carry(carry)
   );

   frac_n_swallow u_swallow (
      .clk(clk), .rst_n(rst_n), .carry(carry), .vco_en(vco_en),
      .remove_cmd(remove_cmd), .pass_en(pass_en)
   );

   frac_n_count #(.NW(NW), .N_RST(N_RST), .FB_MODE(FB_MODE)) u_count (
      .clk(clk), .rst_n(rst_n), .pass_en(pass_en), .n_in(n_in),
      .boundary(boundary), .fb_pulse(fb_pulse)
   );
endmodule

// File: rtl/frac_n_divider_chk.sv
module frac_n_divider_chk #(
   parameter int ACC_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             vco_en,
   input logic             ref_tick,
   input logic             fb_pulse,
   input logic             remove_cmd,
   input logic [ACC_W-1:0] acc_residue,
   input logic             carry,
   input logic             boundary,
   input logic [ACC_W-1:0] f_act_q
);
   // R2: the feedback pulse is one clock wide
   assert_fb_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fb_pulse |=> !fb_pulse);

   // R3: the residue moves only on a reference tick
   assert_residue_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_tick |=> $stable(acc_residue));

   // R4: a carry arms a removal
   assert_carry_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
      carry |=> remove_cmd);

   // R5: an armed removal waits for an enable
   assert_armed_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (remove_cmd && !vco_en) |=> remove_cmd);

   // R5: an armed removal is spent by exactly one enable
   assert_armed_spent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (remove_cmd && vco_en && !carry) |=> !remove_cmd);

   // R6: a swallowed enable never completes a period
   assert_swallow_no_fb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (remove_cmd && vco_en) |=> !fb_pulse);

   // R8: the fractional word changes only at a boundary
   assert_f_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> $stable(f_act_q));
endmodule

bind frac_n_divider frac_n_divider_chk #(.ACC_W(ACC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .vco_en(vco_en), .ref_tick(ref_tick),
   .fb_pulse(fb_pulse), .remove_cmd(remove_cmd), .acc_residue(acc_residue),
   .carry(carry), .boundary(boundary), .f_act_q(f_act_q)
);

// File: tb/frac_n_divider_test.sv
`timescale 1ns/100ps
module frac_n_divider_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vco_en = 1'b0;
   logic        ref_tick = 1'b0;
   logic [7:0]  n_in = 8'd4;
   logic [11:0] f_in = 12'd0;
   logic        fb_pulse;
   logic        remove_cmd;
   logic [11:0] acc_residue;

   int n_checks = 0;
   int n_fails  = 0;

   always #2.5 clk = ~clk;

   frac_n_divider uut (
      .clk(clk), .rst_n(rst_n), .vco_en(vco_en), .ref_tick(ref_tick),
      .n_in(n_in), .f_in(f_in), .fb_pulse(fb_pulse),
      .remove_cmd(remove_cmd), .acc_residue(acc_residue)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic pulse_vco();
      @(negedge clk) vco_en = 1'b1;
      @(negedge clk) vco_en = 1'b0;
   endtask

   task automatic tick_ref();
      @(negedge clk) ref_tick = 1'b1;
      @(negedge clk) ref_tick = 1'b0;
   endtask

   // Enables issued until the feedback pulse shows up.
   task automatic count_to_fb(output int len);
      len = 0;
      for (int i = 0; i < 40; i++) begin
         pulse_vco();
         len++;
         if (fb_pulse) break;
      end
   endtask

   // Reset, then flush n/f across one boundary: empty counter, zero residue.
   task automatic setup(input int n, input int f);
      int dummy;
      @(negedge clk);
      rst_n = 1'b0; vco_en = 1'b0; ref_tick = 1'b0;
      n_in = 8'(n); f_in = 12'(f);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      count_to_fb(dummy);
   endtask

   task automatic t_reset();
      @(negedge clk) rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(fb_pulse == 1'b0, "R1 fb in reset", fb_pulse, 0);
      check(remove_cmd == 1'b0, "R1 remove in reset", remove_cmd, 0);
      check(acc_residue == 12'd0, "R1 residue in reset", acc_residue, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(fb_pulse == 1'b0 && remove_cmd == 1'b0, "R1 after release",
            {fb_pulse, remove_cmd}, 0);
   endtask

   task automatic t_integer();
      int len;
      setup(5, 0);
      count_to_fb(len);
      check(len == 5, "R2 integer period", len, 5);
      @(negedge clk);
      check(fb_pulse == 1'b0, "R2 fb one clock", fb_pulse, 0);
      repeat (3) tick_ref();
      check(remove_cmd == 1'b0, "R9 zero F no removal", remove_cmd, 0);
      check(acc_residue == 12'd0, "R9 zero F residue", acc_residue, 0);
      count_to_fb(len);
      check(len == 5, "R9 zero F period", len, 5);
   endtask

   task automatic t_overflow();
      int len;
      setup(6, 1000);
      for (int k = 1; k <= 4; k++) begin
         tick_ref();
         check(acc_residue == 12'(k * 1000), "R3 residue step", acc_residue, k * 1000);
         check(remove_cmd == 1'b0, "R4 no carry yet", remove_cmd, 0);
      end
      repeat (3) @(negedge clk);
      check(acc_residue == 12'd4000, "R3 residue hold", acc_residue, 4000);
      tick_ref();
      check(acc_residue == 12'd904, "R3 residue wrap", acc_residue, 904);
      check(remove_cmd == 1'b1, "R4 carry arms removal", remove_cmd, 1);
      repeat (4) @(negedge clk);
      check(remove_cmd == 1'b1, "R5 removal held", remove_cmd, 1);
      pulse_vco();
      check(remove_cmd == 1'b0, "R5 removal spent", remove_cmd, 0);
      count_to_fb(len);
      check(len == 6, "R6 remaining after swallow", len, 6);
   endtask

   task automatic t_fraction(input int f, input int long_every);
      int len;
      int longs = 0;
      setup(2, f);
      for (int i = 0; i < 8; i++) begin
         tick_ref();
         count_to_fb(len);
         if (len == 3) longs++;
         check(len == (((i % long_every) == long_every - 1) ? 3 : 2),
               "R7 period length", len, ((i % long_every) == long_every - 1) ? 3 : 2);
      end
      check(longs == 8 / long_every, "R7 long period count", longs, 8 / long_every);
   endtask

   task automatic t_update();
      int len;
      setup(4, 0);
      n_in = 8'd7; f_in = 12'd512;
      pulse_vco();
      pulse_vco();
      tick_ref();
      check(acc_residue == 12'd0, "R8 old F before boundary", acc_residue, 0);
      count_to_fb(len);
      check(len == 2, "R8 old N finishes period", len, 2);
      tick_ref();
      check(acc_residue == 12'd512, "R8 new F after boundary", acc_residue, 512);
      count_to_fb(len);
      check(len == 7, "R8 new N after boundary", len, 7);
   endtask

   initial begin
      #1_000_000;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      t_reset();
      t_integer();
      t_overflow();
      t_fraction(2048, 2);
      t_fraction(1024, 4);
      t_update();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule